// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This block is a purely combinational execution slice for a 64-bit integer core. It receives two source operands, a 6-bit immediate amount and a pair of 6-bit field bounds. A 5-bit operation code picks one of a family of bit-manipulation results. The chosen result appears on the result port in the same cycle. A write-enable goes with it and tells the register file whether the destination should be updated.

The operations are:

- an add that scales the second operand by 2, 4 or 8;
- right rotates by an immediate, over the full width or over the low word;
- signed and unsigned bitfield extraction;
- leading-count operations that find the first zero or the first one, in full and word forms;
- byte reversal, in full and word forms;
- an inverted per-byte "any bit set" mask;
- a single-bit test.

Decode, register file access and pipelining belong to the surrounding core. The block has no clock and no state, so the stream handshake of the house style has no place here. The valid/ready qualification is left to the pipeline stage that holds the operands.

Top module: `bitx_exec`

## Requirements
- R1: Codes 1, 2 and 3 return rs1 + (rs2 << k), where k equals the code (1, 2 or 3), wrapping modulo 2^64; the shift is applied to rs2 only.
- R2: Code 4 returns rs1 rotated right by the 6-bit immediate over 64 bits.
- R3: Code 5 rotates bits 31:0 of rs1 right by immediate bits 4:0 within 32 bits, and sign-extends the 32-bit result from its bit 31.
- R4: Code 6 (signed) and code 7 (unsigned) return bits msb..lsb of rs1 moved down to bit 0. When lsb <= msb, the signed form fills the upper bits with rs1[msb] and the unsigned form fills them with zeros.
- R5: For codes 6 and 7 with lsb > msb, the write-enable is low and the result is zero.
- R6: Code 8 returns the count of leading zeros of ~rs1 (first zero from the top), and code 9 returns the count of leading zeros of rs1. Both give 64 when no bit qualifies.
- R7: Codes 10 (zero) and 11 (one) count in the same way over bits 31:0 only. They give a value from 0 to 32, and 32 when no bit qualifies.
- R8: Code 12 reverses all eight bytes. Code 13 reverses the four bytes of bits 31:0 and sign-extends the 32-bit result from its bit 31.
- R9: Code 14 sets each result byte to 0x00 when the matching rs1 byte is nonzero, and to 0xFF when it is zero.
- R10: Code 15 returns bit number imm of rs1 in bit 0, with all other result bits zero.
- R11: Code 0 and codes 16 to 31 are unsupported. They give a zero result with the write-enable low.
- R12: Every supported code raises the write-enable, except for the extract case in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (see requirements) |
| rs1_i | input | 64 | First source operand |
| rs2_i | input | 64 | Second source operand (used by the scaled add) |
| imm_i | input | 6 | Immediate rotate amount or bit index |
| msb_i | input | 6 | Upper field bound for extraction |
| lsb_i | input | 6 | Lower field bound for extraction |
| result_o | output | 64 | Computed result |
| wr_en_o | output | 1 | Destination write-enable |

## Verification
Every result and its write-enable are due in the same cycle as the inputs, with zero register stages between any input and either output. The bench changes inputs on the falling clock edge. It reads both outputs a fixed two nanoseconds later, well before the next rising edge, so each comparison sees a settled value for exactly one applied stimulus. Directed cases cover:

- all-zero and all-one operands for the counters;
- full-width, single-bit and inverted field bounds for extraction;
- rotates by zero and by maximum amounts;
- sign bits set on word results.

A seeded random sweep over all 32 codes follows the directed cases.

// File: rtl/bitx_pkg.sv
package bitx_pkg;

  typedef enum logic [4:0] {
    BX_NONE   = 5'd0,
    BX_SADD1  = 5'd1,
    BX_SADD2  = 5'd2,
    BX_SADD3  = 5'd3,
    BX_ROR    = 5'd4,
    BX_RORW   = 5'd5,
    BX_EXTS   = 5'd6,
    BX_EXTU   = 5'd7,
    BX_FZ     = 5'd8,
    BX_FO     = 5'd9,
    BX_FZW    = 5'd10,
    BX_FOW    = 5'd11,
    BX_BREV   = 5'd12,
    BX_BREVW  = 5'd13,
    BX_BZMASK = 5'd14,
    BX_BTEST  = 5'd15
  } bitx_op_e;

  localparam int BX_NUM_SADD = 3;

endpackage

// File: rtl/bitx_shift_unit.sv
module bitx_shift_unit #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]                  a_i,
  input  logic [XLEN-1:0]                  b_i,
  input  logic [SHW-1:0]                   sh_i,
  input  logic [SHW-1:0]                   hi_i,
  input  logic [SHW-1:0]                   lo_i,
  output logic [bitx_pkg::BX_NUM_SADD-1:0][XLEN-1:0] sadd_o,
  output logic [XLEN-1:0]                  ror_o,
  output logic [XLEN-1:0]                  rorw_o,
  output logic [XLEN-1:0]                  exts_o,
  output logic [XLEN-1:0]                  extu_o,
  output logic                             ext_ok_o,
  output logic [XLEN-1:0]                  btest_o
);
  localparam int HW = XLEN / 2;

  // scaled adds: second operand shifted by 1..N
  for (genvar k = 1; k <= bitx_pkg::BX_NUM_SADD; k++) begin : g_sadd
    assign sadd_o[k-1] = a_i + (b_i << k);
  end

  // full-width rotate through a doubled operand
  logic [2*XLEN-1:0] dbl_full;
  assign dbl_full = {a_i, a_i} >> sh_i;
  assign ror_o    = dbl_full[XLEN-1:0];

  // word rotate, then sign extension
  logic [2*HW-1:0] dbl_word;
  logic [HW-1:0]   rw;
  assign dbl_word = {a_i[HW-1:0], a_i[HW-1:0]} >> sh_i[SHW-2:0];
  assign rw       = dbl_word[HW-1:0];
  assign rorw_o   = {{(XLEN-HW){rw[HW-1]}}, rw};

  // field extraction
  logic [SHW:0]    fwidth;
  logic [XLEN-1:0] fmask;
  logic [XLEN-1:0] fdown;
  logic            ftop;
  assign ext_ok_o = (lo_i <= hi_i);
  assign fwidth   = {1'b0, hi_i} - {1'b0, lo_i} + {{SHW{1'b0}}, 1'b1};
  assign fmask    = ~({XLEN{1'b1}} << fwidth);
  assign fdown    = (a_i >> lo_i) & fmask;
  assign ftop     = a_i[hi_i];

  always_comb begin
    if (ext_ok_o) begin
      extu_o = fdown;
      exts_o = ftop ? (fdown | ~fmask) : fdown;
    end else begin
      extu_o = '0;
      exts_o = '0;
    end
  end

  // single bit test
  assign btest_o = {{(XLEN-1){1'b0}}, a_i[sh_i]};

endmodule

// File: rtl/bitx_lead_count.sv
module bitx_lead_count #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);
  // highest set bit wins; no set bit yields W
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/bitx_byte_unit.sv
module bitx_byte_unit #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  output logic [XLEN-1:0] brev_o,
  output logic [XLEN-1:0] brevw_o,
  output logic [XLEN-1:0] bzmask_o
);
  localparam int NB  = XLEN / 8;
  localparam int HW  = XLEN / 2;
  localparam int NBW = HW / 8;

  logic [HW-1:0] wrev;

  for (genvar i = 0; i < NB; i++) begin : g_full
    assign brev_o[8*i +: 8]   = a_i[8*(NB-1-i) +: 8];
    assign bzmask_o[8*i +: 8] = (|a_i[8*i +: 8]) ? 8'h00 : 8'hFF;
  end

  for (genvar j = 0; j < NBW; j++) begin : g_word
    assign wrev[8*j +: 8] = a_i[8*(NBW-1-j) +: 8];
  end

  assign brevw_o = {{(XLEN-HW){wrev[HW-1]}}, wrev};
endmodule

// File: rtl/bitx_exec.sv
module bitx_exec #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [4:0]      op_i,
  input  logic [63:0]     rs1_i,
  input  logic [63:0]     rs2_i,
  input  logic [5:0]      imm_i,
  input  logic [5:0]      msb_i,
  input  logic [5:0]      lsb_i,
  output logic [63:0]     result_o,
  output logic            wr_en_o
);
  import bitx_pkg::*;

  localparam int HW = XLEN / 2;
  localparam int CW = SHW + 1;

  logic [BX_NUM_SADD-1:0][XLEN-1:0] sadd;
  logic [XLEN-1:0] ror, rorw, exts, extu, btest;
  logic            ext_ok;
  logic [XLEN-1:0] brev, brevw, bzmask;
  logic [XLEN-1:0] cnt_src;
  logic [CW-1:0]   cnt;
  logic            inv_sel, word_sel;
  bitx_op_e        op;

  assign op = bitx_op_e'(op_i);

  bitx_shift_unit #(.XLEN(XLEN), .SHW(SHW)) u_shift (
    .a_i      (rs1_i),
    .b_i      (rs2_i),
    .sh_i     (imm_i),
    .hi_i     (msb_i),
    .lo_i     (lsb_i),
    .sadd_o   (sadd),
    .ror_o    (ror),
    .rorw_o   (rorw),
    .exts_o   (exts),
    .extu_o   (extu),
    .ext_ok_o (ext_ok),
    .btest_o  (btest)
  );

  bitx_byte_unit #(.XLEN(XLEN)) u_byte (
    .a_i      (rs1_i),
    .brev_o   (brev),
    .brevw_o  (brevw),
    .bzmask_o (bzmask)
  );

  // one shared counter: word forms place the low word on top and plant
  // a stop bit just below it, capping the count at HW
  assign inv_sel  = (op == BX_FZ) || (op == BX_FZW);
  assign word_sel = (op == BX_FZW) || (op == BX_FOW);

  always_comb begin
    logic [XLEN-1:0] v;
    v = inv_sel ? ~rs1_i : rs1_i;
    if (word_sel) cnt_src = {v[HW-1:0], 1'b1, {(HW-1){1'b0}}};
    else          cnt_src = v;
  end

  bitx_lead_count #(.W(XLEN), .CW(CW)) u_cnt (
    .val_i (cnt_src),
    .cnt_o (cnt)
  );

  always_comb begin
    result_o = '0;
    wr_en_o  = 1'b1;
    unique case (op)
      BX_SADD1:  result_o = sadd[0];
      BX_SADD2:  result_o = sadd[1];
      BX_SADD3:  result_o = sadd[2];
      BX_ROR:    result_o = ror;
      BX_RORW:   result_o = rorw;
      BX_EXTS:   begin result_o = exts; wr_en_o = ext_ok; end
      BX_EXTU:   begin result_o = extu; wr_en_o = ext_ok; end
      BX_FZ, BX_FO, BX_FZW, BX_FOW:
                 result_o = {{(XLEN-CW){1'b0}}, cnt};
      BX_BREV:   result_o = brev;
      BX_BREVW:  result_o = brevw;
      BX_BZMASK: result_o = bzmask;
      BX_BTEST:  result_o = btest;
      default:   wr_en_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/bitx_exec_chk.sv
module bitx_exec_chk (
  input logic [4:0]  op_i,
  input logic [63:0] rs1_i,
  input logic [5:0]  imm_i,
  input logic [5:0]  msb_i,
  input logic [5:0]  lsb_i,
  input logic [63:0] result_o,
  input logic        wr_en_o
);
  always_comb begin
    if (op_i == 5'd0 || op_i >= 5'd16) begin
      assert_unsup_quiet_R11: assert (!wr_en_o && result_o == 64'd0)
        else $error("unsupported code produced output");
    end
    if ((op_i == 5'd6 || op_i == 5'd7) && lsb_i > msb_i) begin
      assert_ext_nowrite_R5: assert (!wr_en_o && result_o == 64'd0)
        else $error("inverted field bounds wrote");
    end
    if (op_i >= 5'd1 && op_i <= 5'd15 && !(op_i == 5'd6 || op_i == 5'd7)) begin
      assert_write_on_R12: assert (wr_en_o) else $error("write-enable low");
    end
    if (op_i == 5'd15) begin
      assert_btest_onebit_R10: assert (result_o[63:1] == 63'd0 && result_o[0] == rs1_i[imm_i])
        else $error("bit test result wrong shape");
    end
    if (op_i == 5'd5) begin
      assert_rorw_sext_R3: assert (result_o[63:32] == {32{result_o[31]}})
        else $error("word rotate not sign-extended");
    end
    if (op_i == 5'd13) begin
      assert_brevw_sext_R8: assert (result_o[63:32] == {32{result_o[31]}})
        else $error("word byte reverse not sign-extended");
    end
    if (op_i == 5'd8 || op_i == 5'd9) begin
      assert_cnt_range_R6: assert (result_o <= 64'd64) else $error("count above 64");
    end
    if (op_i == 5'd10 || op_i == 5'd11) begin
      assert_cntw_range_R7: assert (result_o <= 64'd32) else $error("word count above 32");
    end
  end
endmodule

bind bitx_exec bitx_exec_chk u_bitx_exec_chk (
  .op_i     (op_i),
  .rs1_i    (rs1_i),
  .imm_i    (imm_i),
  .msb_i    (msb_i),
  .lsb_i    (lsb_i),
  .result_o (result_o),
  .wr_en_o  (wr_en_o)
);

// File: tb/test_bitx_exec.sv
`timescale 1ns/1ps
module test_bitx_exec;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  op;
  logic [63:0] rs1, rs2;
  logic [5:0]  imm, msb, lsb;
  logic [63:0] result;
  logic        wr_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  bitx_exec i_bitx_exec (
    .op_i(op), .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm),
    .msb_i(msb), .lsb_i(lsb), .result_o(result), .wr_en_o(wr_en)
  );

  function automatic string req_of(input logic [4:0] c);
    case (c)
      5'd1, 5'd2, 5'd3: return "R1";
      5'd4:             return "R2";
      5'd5:             return "R3";
      5'd6, 5'd7:       return "R4/R5";
      5'd8, 5'd9:       return "R6";
      5'd10, 5'd11:     return "R7";
      5'd12, 5'd13:     return "R8";
      5'd14:            return "R9";
      5'd15:            return "R10";
      default:          return "R11";
    endcase
  endfunction

  function automatic logic [63:0] lead(input logic [63:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) if (v[i]) return 64'(w - 1 - i);
    return 64'(w);
  endfunction

  // returns {write-enable, result}
  function automatic logic [64:0] model(input logic [4:0] c, input logic [63:0] a,
                                        input logic [63:0] b, input logic [5:0] s,
                                        input logic [5:0] hi, input logic [5:0] lo);
    logic [63:0] r;
    logic [31:0] w;
    r = '0;
    case (c)
      5'd1, 5'd2, 5'd3: r = a + b * (64'd1 << c);
      5'd4: for (int i = 0; i < 64; i++) r[i] = a[(i + s) % 64];
      5'd5: begin
        for (int i = 0; i < 32; i++) w[i] = a[(i + s[4:0]) % 32];
        r = {{32{w[31]}}, w};
      end
      5'd6, 5'd7: begin
        if (lo > hi) return {1'b0, 64'd0};
        for (int i = 0; i < 64; i++)
          if (i <= hi - lo) r[i] = a[lo + i];
          else              r[i] = (c == 5'd6) ? a[hi] : 1'b0;
      end
      5'd8:  r = lead(~a, 64);
      5'd9:  r = lead(a, 64);
      5'd10: r = lead({32'd0, ~a[31:0]}, 32);
      5'd11: r = lead({32'd0, a[31:0]}, 32);
      5'd12: for (int i = 0; i < 8; i++) r[8*i +: 8] = a[56 - 8*i +: 8];
      5'd13: begin
        for (int i = 0; i < 4; i++) w[8*i +: 8] = a[24 - 8*i +: 8];
        r = {{32{w[31]}}, w};
      end
      5'd14: for (int i = 0; i < 8; i++) r[8*i +: 8] = (a[8*i +: 8] == 8'd0) ? 8'hFF : 8'h00;
      5'd15: r = {63'd0, a[s]};
      default: return {1'b0, 64'd0};
    endcase
    return {1'b1, r};
  endfunction

  task automatic apply(input logic [4:0] c, input logic [63:0] a, input logic [63:0] b,
                       input logic [5:0] s, input logic [5:0] hi, input logic [5:0] lo,
                       input string tag);
    logic [64:0] exp;
    @(negedge clk);
    op = c; rs1 = a; rs2 = b; imm = s; msb = hi; lsb = lo;
    #2;
    exp = model(c, a, b, s, hi, lo);
    n_tests++;
    if ({wr_en, result} !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d: got we=%b res=%h, expected we=%b res=%h",
               tag, req_of(c), c, wr_en, result, exp[64], exp[63:0]);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    op = '0; rs1 = '0; rs2 = '0; imm = '0; msb = '0; lsb = '0;
    seed = $urandom(32'd2024);
    // idle state: code 0 (R11)
    apply(5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 6'd3, 6'd2, 6'd1, "idle_R11");
    // R1 second operand is the shifted one
    apply(5'd1, 64'd100, 64'd3, 0, 0, 0, "sadd1_R1");
    apply(5'd3, 64'd1, 64'hF000_0000_0000_0001, 0, 0, 0, "sadd3_wrap_R1");
    // R2, R3 rotates
    apply(5'd4, 64'h0123_4567_89AB_CDEF, 0, 6'd0, 0, 0, "ror0_R2");
    apply(5'd4, 64'h0000_0000_0000_0001, 0, 6'd63, 0, 0, "ror63_R2");
    apply(5'd5, 64'hDEAD_0000_0000_0001, 0, 6'd1, 0, 0, "rorw_sign_R3");
    apply(5'd5, 64'h0000_0000_8000_0000, 0, 6'd32, 0, 0, "rorw_hi_ignored_R3");
    // R4, R5 extraction
    apply(5'd6, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 6'd63, 6'd0, "exts_full_R4");
    apply(5'd6, 64'h0000_0000_0000_0080, 0, 0, 6'd7, 6'd4, "exts_neg_R4");
    apply(5'd7, 64'h0000_0000_0000_0080, 0, 0, 6'd7, 6'd4, "extu_R4");
    apply(5'd7, 64'h8000_0000_0000_0000, 0, 0, 6'd63, 6'd63, "extu_onebit_R4");
    apply(5'd6, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 6'd3, 6'd4, "ext_inverted_R5");
    apply(5'd7, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 6'd0, 6'd63, "extu_inverted_R5");
    // R6, R7 counts
    apply(5'd9, 64'd0, 0, 0, 0, 0, "fo_zero_R6");
    apply(5'd8, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, "fz_ones_R6");
    apply(5'd8, 64'hFFF0_0000_0000_0000, 0, 0, 0, 0, "fz_R6");
    apply(5'd11, 64'hFFFF_FFFF_0000_0000, 0, 0, 0, 0, "fow_zero_R7");
    apply(5'd10, 64'h0000_0000_FFFF_FFFF, 0, 0, 0, 0, "fzw_ones_R7");
    apply(5'd11, 64'h0000_0000_0000_0100, 0, 0, 0, 0, "fow_R7");
    // R8, R9, R10
    apply(5'd12, 64'h0102_0304_0506_0708, 0, 0, 0, 0, "brev_R8");
    apply(5'd13, 64'h1111_1111_0000_0080, 0, 0, 0, 0, "brevw_sign_R8");
    apply(5'd14, 64'h0001_0000_FF00_1000, 0, 0, 0, 0, "bzmask_R9");
    apply(5'd15, 64'h8000_0000_0000_0000, 0, 6'd63, 0, 0, "btest_top_R10");
    apply(5'd15, 64'hFFFF_FFFF_FFFF_FFFE, 0, 6'd0, 0, 0, "btest_zero_R10");
    // R11, R12 across codes
    apply(5'd16, 64'h1234, 64'h5678, 6'd5, 6'd9, 6'd2, "unsup16_R11");
    apply(5'd31, 64'h1234, 64'h5678, 6'd5, 6'd9, 6'd2, "unsup31_R11");
    // random sweep: write-enable per code covers R12
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] a, b;
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      if (n % 7 == 0) a = a & {8{8'h0F ^ 8'($urandom() % 2 * 15)}};
      apply(5'($urandom()), a, b, 6'($urandom()), 6'($urandom()), 6'($urandom()), "rand_R12");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule